// File: doc/BRIEF.md
# Full-Speed USB Receive Bit Helper

This block sits behind a clock-recovery stage on the receive side of a full-speed USB port. For every recovered bit time it takes one sample of the differential pair, qualified by a bit strobe. It reports a single-ended zero on the line and turns the NRZI line code back into data bits. It throws away the bits that the transmitter inserted after long runs of ones, and packs the remaining data bits into bytes, least significant bit first. Software above it sees only whole bytes, an end-of-packet pulse and an error pulse. CRC checking and packet parsing are left to that software.

The J (idle) state is D+ high with D- low. A data bit is 1 when the line level does not change from the previous bit time and 0 when it does. A configuration input can bypass the NRZI decode so that D+ is taken as the data bit directly. An enable input holds the whole receiver in its idle state.

Top module: `usbRxDestuffer`

## Requirements
- R1: `se0` is high, without a clock delay, exactly when both `dPlus` and `dMinus` are low.
- R2: With `nrziEn` high, a strobed non-SE0 sample decodes to 1 when `dPlus` equals the level of the previous non-SE0 strobe and to 0 when it differs. The reference level is J (`dPlus` = 1) after reset, while `enable` is low, and after an end of packet.
- R3: With `nrziEn` low, the data bit of a strobed non-SE0 sample is the `dPlus` value itself.
- R4: Data bits fill a byte LSB first. On the clock after the strobe of the eighth data bit, `byteValid` is high for exactly one clock and `rxByte` holds the byte. `rxByte` holds that value until the next byte completes.
- R5: After six consecutive data 1s, the next bit is a stuff bit. If it is 0, it is dropped, it does not advance the byte bit position, and the ones run restarts. Any data 0 also restarts the ones run.
- R6: If the bit that follows six consecutive 1s is a 1, `stuffErr` pulses for one clock on the clock after that strobe. That bit is dropped, and both the ones run and the byte bit position are cleared.
- R7: A strobed J sample that follows two or more consecutive strobed SE0 samples gives a one-clock `eop` pulse on the next clock. It clears the ones run and the byte bit position, and it carries no data bit.
- R8: While `enable` is low, strobes have no effect. No pulse is produced, and a partly received byte is discarded, so reception restarts at bit 0 with a J reference.
- R9: After reset, `byteValid`, `eop` and `stuffErr` are low and `rxByte` is 0.
- R10: A strobed SE0 sample never shifts a data bit and never completes a byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Receiver enable; low holds the idle state |
| nrziEn | input | 1 | 1: NRZI decode, 0: D+ taken as the raw data bit |
| dPlus | input | 1 | Sampled D+ level |
| dMinus | input | 1 | Sampled D- level |
| bitStrobe | input | 1 | One-clock strobe marking a recovered bit time |
| rxByte | output | 8 | Last completed byte, LSB received first |
| byteValid | output | 1 | One-clock pulse when a byte completes |
| se0 | output | 1 | Both lines low |
| eop | output | 1 | One-clock end-of-packet pulse |
| stuffErr | output | 1 | One-clock pulse on a stuff violation |

## Verification
The bench has its own transmitter model. It serialises bytes LSB first, inserts a 0 after every six 1s and NRZI-encodes the result, so each byte and each pulse the receiver reports can be compared with what was sent. Runs of 0x00 toggle the line on every bit and test transition decoding. Runs of 0xFF and 0x3F force stuff bits, including inside a byte and across a byte boundary, and show whether stuff bits are dropped without moving the byte alignment. Random packets with random gaps between strobes cover general byte contents and strobe timing. Directed cases cover the raw mode, seven 1s in a row, disabling the receiver in the middle of a byte, and the SE0-SE0-J end-of-packet sequence. Each of these checks that alignment and the NRZI reference recover cleanly.

// File: rtl/usbRxPkg.sv
package usbRxPkg;
  // Strobes from the control sequencer to the datapath for one clock.
  typedef struct packed {
    logic idle;      // receiver disabled: park the reference at J
    logic levelUpd;  // capture the current line level as the NRZI reference
    logic shiftEn;   // shift the decoded bit into the byte register
    logic loadByte;  // eighth data bit: present the byte
    logic endPkt;    // end of packet recognised
    logic stuffFail; // stuff rule broken
  } rxCtrlS;
endpackage

// File: rtl/usbRxControl.sv
module usbRxControl
  import usbRxPkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int MAX_RUN = 6,
  parameter int EOP_SE0 = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   enable,
  input  logic   bitStrobe,
  input  logic   lineSe0,
  input  logic   lineJ,
  input  logic   dataBit,
  output rxCtrlS ctrl
);
  localparam int RUN_W = $clog2(MAX_RUN + 1);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam int SE0_W = $clog2(EOP_SE0 + 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(MAX_RUN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [SE0_W-1:0] SE0_NEED = SE0_W'(EOP_SE0);

  logic [RUN_W-1:0] onesRun;
  logic [CNT_W-1:0] bitCnt;
  logic [SE0_W-1:0] se0Cnt;
  logic             active;
  logic             runFull;

  assign active  = enable & bitStrobe;
  assign runFull = (onesRun == RUN_MAX);

  always_comb begin
    ctrl      = '0;
    ctrl.idle = ~enable;
    if (active && !lineSe0) begin
      ctrl.levelUpd = 1'b1;
      if (se0Cnt == SE0_NEED && lineJ) begin
        ctrl.endPkt = 1'b1;
      end else if (runFull) begin
        ctrl.stuffFail = dataBit;
      end else begin
        ctrl.shiftEn  = 1'b1;
        ctrl.loadByte = (bitCnt == CNT_LAST);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onesRun <= '0;
      bitCnt  <= '0;
      se0Cnt  <= '0;
    end else if (!enable) begin
      onesRun <= '0;
      bitCnt  <= '0;
      se0Cnt  <= '0;
    end else if (active) begin
      if (lineSe0) begin
        if (se0Cnt != SE0_NEED) se0Cnt <= se0Cnt + 1'b1;
      end else begin
        se0Cnt <= '0;
        if (ctrl.endPkt || ctrl.stuffFail) begin
          onesRun <= '0;
          bitCnt  <= '0;
        end else if (runFull) begin
          onesRun <= '0;
        end else begin
          bitCnt  <= (bitCnt == CNT_LAST) ? '0 : bitCnt + 1'b1;
          onesRun <= dataBit ? onesRun + 1'b1 : '0;
        end
      end
    end
  end
endmodule

// File: rtl/usbRxDatapath.sv
module usbRxDatapath
  import usbRxPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nrziEn,
  input  logic              dPlus,
  input  rxCtrlS            ctrl,
  output logic              dataBit,
  output logic [BYTE_W-1:0] rxByte,
  output logic              byteValid,
  output logic              eop,
  output logic              stuffErr
);
  logic              prevLevel;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] nextShift;

  assign dataBit   = nrziEn ? ~(dPlus ^ prevLevel) : dPlus;
  assign nextShift = {dataBit, shiftReg[BYTE_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLevel <= 1'b1;
    end else if (ctrl.idle || ctrl.endPkt) begin
      prevLevel <= 1'b1;
    end else if (ctrl.levelUpd) begin
      prevLevel <= dPlus;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxByte   <= '0;
    end else begin
      if (ctrl.shiftEn) shiftReg <= nextShift;
      if (ctrl.loadByte) rxByte <= nextShift;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteValid <= 1'b0;
      eop       <= 1'b0;
      stuffErr  <= 1'b0;
    end else begin
      byteValid <= ctrl.loadByte;
      eop       <= ctrl.endPkt;
      stuffErr  <= ctrl.stuffFail;
    end
  end
endmodule

// File: rtl/usbRxDestuffer.sv
module usbRxDestuffer
  import usbRxPkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int MAX_RUN = 6,
  parameter int EOP_SE0 = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              nrziEn,
  input  logic              dPlus,
  input  logic              dMinus,
  input  logic              bitStrobe,
  output logic [BYTE_W-1:0] rxByte,
  output logic              byteValid,
  output logic              se0,
  output logic              eop,
  output logic              stuffErr
);
  rxCtrlS ctrl;
  logic   dataBit;
  logic   lineJ;

  assign se0   = ~dPlus & ~dMinus;
  assign lineJ = dPlus & ~dMinus;

  usbRxControl #(
    .BYTE_W(BYTE_W), .MAX_RUN(MAX_RUN), .EOP_SE0(EOP_SE0)
  ) i_control (
    .clk(clk), .rstN(rstN), .enable(enable), .bitStrobe(bitStrobe),
    .lineSe0(se0), .lineJ(lineJ), .dataBit(dataBit), .ctrl(ctrl)
  );

  usbRxDatapath #(
    .BYTE_W(BYTE_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .nrziEn(nrziEn), .dPlus(dPlus), .ctrl(ctrl),
    .dataBit(dataBit), .rxByte(rxByte), .byteValid(byteValid),
    .eop(eop), .stuffErr(stuffErr)
  );
endmodule

// File: rtl/usbRxChecker.sv
module usbRxChecker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              dPlus,
  input logic              dMinus,
  input logic              bitStrobe,
  input logic [BYTE_W-1:0] rxByte,
  input logic              byteValid,
  input logic              se0,
  input logic              eop,
  input logic              stuffErr
);
  AST_VALID_ONE_CLK: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid); // R4
  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(bitStrobe && enable)); // R4
  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |-> $stable(rxByte)); // R4
  AST_ERR_NOT_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    !(stuffErr && byteValid)); // R6
  AST_EOP_ON_J: assert property (@(posedge clk) disable iff (!rstN)
    eop |-> $past(bitStrobe && dPlus && !dMinus)); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enable) |-> (!byteValid && !eop && !stuffErr)); // R8
  AST_SE0_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $past(se0 && bitStrobe) |-> !byteValid); // R10
endmodule

bind usbRxDestuffer usbRxChecker #(.BYTE_W(BYTE_W)) i_checker (
  .clk(clk), .rstN(rstN), .enable(enable), .dPlus(dPlus), .dMinus(dMinus),
  .bitStrobe(bitStrobe), .rxByte(rxByte), .byteValid(byteValid),
  .se0(se0), .eop(eop), .stuffErr(stuffErr)
);

// File: tb/test_usbRxDestuffer.sv
module test_usbRxDestuffer;
  logic       clk = 1'b0;
  logic       rstN, enable, nrziEn, dPlus, dMinus, bitStrobe;
  logic [7:0] rxByte;
  logic       byteValid, se0, eop, stuffErr;

  always #10 clk = ~clk;

  usbRxDestuffer i_usbRxDestuffer (
    .clk(clk), .rstN(rstN), .enable(enable), .nrziEn(nrziEn),
    .dPlus(dPlus), .dMinus(dMinus), .bitStrobe(bitStrobe),
    .rxByte(rxByte), .byteValid(byteValid), .se0(se0), .eop(eop),
    .stuffErr(stuffErr)
  );

  int nChecks = 0;
  int nFail   = 0;
  logic [7:0] pkt[16];
  logic line;
  int   ones;
  logic gotValid, gotEop, gotErr, gotSe0;
  logic [7:0] gotByte;

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  // One bit time: drive the pair with a one-clock strobe, sample the pulses
  // at the following falling edge, then leave a random gap.
  task automatic strobeLine(input logic dp, input logic dm);
    @(negedge clk);
    dPlus = dp; dMinus = dm; bitStrobe = 1'b1;
    #1 gotSe0 = se0;
    @(negedge clk);
    bitStrobe = 1'b0;
    gotValid = byteValid; gotEop = eop; gotErr = stuffErr; gotByte = rxByte;
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, input logic raw);
    logic lv;
    if (raw) lv = b;
    else begin
      if (!b) line = ~line;
      lv = line;
    end
    strobeLine(lv, ~lv);
  endtask

  task automatic sendEop();
    strobeLine(1'b0, 1'b0);
    check("R1", gotSe0, 1, "se0 during SE0 strobe");
    check("R10", gotValid, 0, "byteValid after SE0");
    strobeLine(1'b0, 1'b0);
    strobeLine(1'b1, 1'b0);
    check("R7", gotEop, 1, "eop after SE0 SE0 J");
    check("R7", gotValid, 0, "J after EOP carries no data");
    line = 1'b1;
  endtask

  // Transmitter model: LSB first, stuff a 0 after six 1s, NRZI unless raw.
  task automatic sendPacket(input int n, input logic raw, input string tag);
    int bad = 0;
    line = 1'b1; ones = 0;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 8; k++) begin
        logic b;
        b = pkt[i][k];
        sendBit(b, raw);
        if (k == 7) begin
          check(tag, gotValid, 1, "byteValid on eighth bit");
          check(tag, gotByte, pkt[i], "rxByte");
        end else if (gotValid) bad++;
        if (gotErr || gotEop) bad++;
        ones = b ? ones + 1 : 0;
        if (ones == 6) begin
          sendBit(1'b0, raw);
          if (gotValid || gotErr || gotEop) bad++;
          ones = 0;
        end
      end
    end
    check("R5", bad, 0, "spurious pulses inside packet");
    sendEop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; enable = 1'b1; nrziEn = 1'b1;
    dPlus = 1'b1; dMinus = 1'b0; bitStrobe = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", byteValid, 0, "byteValid in reset");
    check("R9", eop, 0, "eop in reset");
    check("R9", stuffErr, 0, "stuffErr in reset");
    check("R9", rxByte, 0, "rxByte in reset");
    rstN = 1'b1;
    @(negedge clk);

    dPlus = 1'b0; dMinus = 1'b0; #1;
    check("R1", se0, 1, "se0 both low");
    dPlus = 1'b0; dMinus = 1'b1; #1;
    check("R1", se0, 0, "se0 on K");
    dPlus = 1'b1; dMinus = 1'b0; #1;
    check("R1", se0, 0, "se0 on J");

    // Transitions on every bit, then mixed levels.
    pkt[0] = 8'h00; pkt[1] = 8'hA5; pkt[2] = 8'h80;
    sendPacket(3, 1'b0, "R2");

    // Stuff bits within and across bytes.
    pkt[0] = 8'h3F; pkt[1] = 8'hFF; pkt[2] = 8'hFF; pkt[3] = 8'h7E;
    sendPacket(4, 1'b0, "R5");

    // Raw mode: D+ is the data bit.
    nrziEn = 1'b0;
    pkt[0] = 8'hFF; pkt[1] = 8'h3C; pkt[2] = 8'h01;
    sendPacket(3, 1'b1, "R3");
    nrziEn = 1'b1;

    // Seven 1s in a row: stuff violation, then clean realignment.
    for (int i = 0; i < 7; i++) strobeLine(1'b1, 1'b0);
    check("R6", gotErr, 1, "stuffErr on seventh one");
    check("R6", gotValid, 0, "no byte on stuff violation");
    pkt[0] = 8'hC3; pkt[1] = 8'h5A;
    sendPacket(2, 1'b0, "R6");

    // Disable in mid-byte; strobes while disabled are ignored.
    line = 1'b1;
    for (int i = 0; i < 4; i++) sendBit(1'b0, 1'b0);
    enable = 1'b0;
    begin
      int bad = 0;
      for (int i = 0; i < 16; i++) begin
        strobeLine(i[0], ~i[0]);
        if (gotValid || gotEop || gotErr) bad++;
      end
      check("R8", bad, 0, "pulses while disabled");
    end
    enable = 1'b1;
    pkt[0] = 8'h96; pkt[1] = 8'h0F;
    sendPacket(2, 1'b0, "R8");

    // Random packets.
    for (int p = 0; p < 25; p++) begin
      int n;
      n = $urandom_range(1, 8);
      for (int i = 0; i < n; i++) begin
        pkt[i] = 8'($urandom());
        if ($urandom_range(0, 3) == 0) pkt[i] = 8'hFF;
      end
      sendPacket(n, 1'b0, "R4");
    end

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule